// File: doc/BRIEF.md
# Fail-Safe Supervisor State Controller

This block is the sequencing core of a safety supervisor chip. It moves between four operating states (held in reset, diagnostic, active and safe) in response to abstracted event inputs: a global safe condition, a global reset condition, the counts reported by an MCU error-signal monitor and by a watchdog, and commands to enter the active state, to leave the safe state and to write configuration. Interface decoding, watchdog question generation, self-test engines and analog monitors sit outside and are seen here only as levels and counts.

The controller keeps a saturating device error counter. Each fault-driven entry into the safe state adds one to it. Once the counter reaches a programmable lock threshold, every exit from the reset state leads straight back into the safe state, and this holds across any number of resets. A programmable timeout sends the machine from safe to reset if the MCU does not respond. The timeout can be switched off only when a disable bit is set and the error counter has passed the lock threshold. While in safe, a watchdog reset request is held off until the MCU issues the exit command.

Top module: `fs_supervisor`

## Requirements
- R1: `state_o` encodes reset as 0, diagnostic as 1, active as 2 and safe as 3. From diagnostic or active, a high `glb_safe_i`, or `mcu_fail_cnt_i >= mcu_fail_th_i` with a nonzero threshold, moves the state to safe at the next clock edge. `go_active_i` moves diagnostic to active.
- R2: When the reset state ends and the lock is active, the next state is safe instead of diagnostic. The lock is active when `lock threshold != 0` and `err_cnt_o >= lock threshold`, and it is reported on `safe_lock_o`. Entering safe from reset leaves `err_cnt_o` unchanged.
- R3: Entering safe from diagnostic or active raises `err_cnt_o` by one.
- R4: In safe, `endrv_n_o` is 0, `nres_o` is 1 and `drv_en_o` is 0. The driver-enable bit is cleared on entry and cannot be written while in safe.
- R5: In diagnostic or active, when watchdog reset is enabled and `wd_fail_cnt_i >= wd_rst_th_i`, the state goes to reset. In safe the same condition is ignored.
- R6: In safe, `safe_exit_i` moves the state to reset if watchdog reset is enabled and `wd_fail_cnt_i >= wd_rst_th_i`, and to diagnostic otherwise.
- R7: In safe, the timeout expires after `TO_BASE << sel` cycles, where `sel` is the 2-bit timeout setting, and expiry moves the state to reset. The timeout is off exactly when the disable bit is 1 and `err_cnt_o` is greater than the lock threshold, which is reported on `to_off_o`.
- R8: After `rst_n` the disable bit is 1, the lock threshold is 0, the watchdog reset enable is 1, the timeout setting is 0 and the driver enable is 0. A `cfg_wr_i` pulse writes the disable bit and the lock threshold only in diagnostic. The timeout setting and the watchdog enable are written in any state. The driver enable is written in diagnostic or active.
- R9: A high `glb_reset_i` moves any state to reset, and it takes priority over every other event. `nres_o` is 0 exactly while in reset. The reset state ends `RST_EXT` cycles after `glb_reset_i` was last seen high, or after entry if it was never high.
- R10: `err_cnt_o` never decreases and saturates at its maximum value (15 for 4 bits) instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| glb_safe_i | input | 1 | Global safe condition |
| glb_reset_i | input | 1 | Global reset condition |
| go_active_i | input | 1 | Command: diagnostic to active |
| safe_exit_i | input | 1 | Command: leave safe |
| mcu_fail_cnt_i | input | FC_W | MCU error-signal failure count |
| mcu_fail_th_i | input | FC_W | MCU failure threshold (0 = off) |
| wd_fail_cnt_i | input | FC_W | Watchdog failure count |
| wd_rst_th_i | input | FC_W | Watchdog reset threshold |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_to_dis_i | input | 1 | Timeout disable bit value |
| cfg_lock_th_i | input | ERR_W | Lock threshold value |
| cfg_to_sel_i | input | 2 | Timeout length setting |
| cfg_wd_rst_en_i | input | 1 | Watchdog reset enable value |
| cfg_drv_en_i | input | 1 | Driver enable value |
| state_o | output | 2 | Current state |
| nres_o | output | 1 | Active-low reset output |
| endrv_n_o | output | 1 | Active-low enable/interrupt output |
| drv_en_o | output | 1 | Driver enable control bit |
| err_cnt_o | output | ERR_W | Device error counter |
| safe_lock_o | output | 1 | Lock condition active |
| to_off_o | output | 1 | Safe timeout currently disabled |

## Verification
The bound checker checks on every cycle the output levels in safe, the monotonic and saturating error counter, the increment on fault-driven safe entry and its absence on entry from reset, the freezing of the disable bit and lock threshold outside diagnostic, the priority of global reset, and that an exit command always leaves safe. Only the directed scenarios show the exact timeout lengths for each setting, the reset-extension length, the return to safe after resets while locked, the masking of a pending watchdog reset in safe, and the reset-time defaults of the configuration.

// File: rtl/fs_pkg.sv
package fs_pkg;
   typedef enum logic [1:0] {
      ST_RESET  = 2'd0,
      ST_DIAG   = 2'd1,
      ST_ACTIVE = 2'd2,
      ST_SAFE   = 2'd3
   } fs_state_e;

   localparam int SEL_W = 2;
endpackage

// File: rtl/fs_err_counter.sv
module fs_err_counter #(
   parameter int ERR_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc_i,
   output logic [ERR_W-1:0] cnt_o
);
   localparam logic [ERR_W-1:0] CNT_MAX = '1;

   logic [ERR_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (inc_i && (cnt_q != CNT_MAX)) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign cnt_o = cnt_q;
endmodule

// File: rtl/fs_timer.sv
module fs_timer #(
   parameter int TO_BASE = 256,
   parameter int RST_EXT = 16,
   parameter int SEL_W   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   input  logic             run_i,
   input  logic             safe_mode_i,
   input  logic [SEL_W-1:0] to_sel_i,
   output logic             done_o
);
   localparam int MAX_SAFE = TO_BASE << ((1 << SEL_W) - 1);
   localparam int TW       = $clog2(MAX_SAFE + RST_EXT + 1);
   localparam bit BASE_P2  = (TO_BASE & (TO_BASE - 1)) == 0;

   logic [TW-1:0] cnt_q;
   logic [TW-1:0] safe_lim;
   logic [TW-1:0] limit;

   generate
      if (BASE_P2) begin : g_shift_lim
         localparam int LOG_BASE = $clog2(TO_BASE);
         always_comb begin
            safe_lim = TW'(1) << (TW'(LOG_BASE) + TW'(to_sel_i));
         end
      end else begin : g_mul_lim
         always_comb begin
            safe_lim = TW'(TO_BASE) << to_sel_i;
         end
      end
   endgenerate

   assign limit  = safe_mode_i ? safe_lim : TW'(RST_EXT);
   assign done_o = run_i && (cnt_q == (limit - 1'b1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clear_i) begin
         cnt_q <= '0;
      end else if (run_i && !done_o) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/fs_cfg_regs.sv
module fs_cfg_regs
   import fs_pkg::*;
#(
   parameter int ERR_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  fs_state_e        state_q_i,
   input  fs_state_e        state_d_i,
   input  logic             wr_i,
   input  logic             to_dis_i,
   input  logic [ERR_W-1:0] lock_th_i,
   input  logic [SEL_W-1:0] to_sel_i,
   input  logic             wd_rst_en_i,
   input  logic             drv_en_i,
   output logic             to_dis_o,
   output logic [ERR_W-1:0] lock_th_o,
   output logic [SEL_W-1:0] to_sel_o,
   output logic             wd_rst_en_o,
   output logic             drv_en_o
);
   logic in_diag;
   logic in_run;

   assign in_diag = (state_q_i == ST_DIAG);
   assign in_run  = in_diag || (state_q_i == ST_ACTIVE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         to_dis_o    <= 1'b1;
         lock_th_o   <= '0;
         to_sel_o    <= '0;
         wd_rst_en_o <= 1'b1;
      end else if (wr_i) begin
         to_sel_o    <= to_sel_i;
         wd_rst_en_o <= wd_rst_en_i;
         if (in_diag) begin
            to_dis_o  <= to_dis_i;
            lock_th_o <= lock_th_i;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         drv_en_o <= 1'b0;
      end else if (state_d_i == ST_SAFE) begin
         drv_en_o <= 1'b0;
      end else if (wr_i && in_run) begin
         drv_en_o <= drv_en_i;
      end
   end
endmodule

// File: rtl/fs_state_core.sv
module fs_state_core
   import fs_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      glb_reset_i,
   input  logic      glb_safe_i,
   input  logic      mcu_trip_i,
   input  logic      wd_trip_i,
   input  logic      go_active_i,
   input  logic      safe_exit_i,
   input  logic      lock_i,
   input  logic      tmr_done_i,
   output fs_state_e state_q_o,
   output fs_state_e state_d_o,
   output logic      safe_inc_o
);
   fs_state_e state_q;
   fs_state_e state_d;

   always_comb begin
      state_d    = state_q;
      safe_inc_o = 1'b0;
      if (glb_reset_i) begin
         state_d = ST_RESET;
      end else begin
         case (state_q)
            ST_RESET: begin
               if (tmr_done_i) begin
                  state_d = lock_i ? ST_SAFE : ST_DIAG;
               end
            end
            ST_DIAG, ST_ACTIVE: begin
               if (glb_safe_i || mcu_trip_i) begin
                  state_d    = ST_SAFE;
                  safe_inc_o = 1'b1;
               end else if (wd_trip_i) begin
                  state_d = ST_RESET;
               end else if ((state_q == ST_DIAG) && go_active_i) begin
                  state_d = ST_ACTIVE;
               end
            end
            ST_SAFE: begin
               if (safe_exit_i) begin
                  state_d = wd_trip_i ? ST_RESET : ST_DIAG;
               end else if (tmr_done_i) begin
                  state_d = ST_RESET;
               end
            end
            default: state_d = ST_RESET;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_RESET;
      end else begin
         state_q <= state_d;
      end
   end

   assign state_q_o = state_q;
   assign state_d_o = state_d;
endmodule

// File: rtl/fs_supervisor.sv
module fs_supervisor
   import fs_pkg::*;
#(
   parameter int ERR_W   = 4,
   parameter int FC_W    = 4,
   parameter int TO_BASE = 256,
   parameter int RST_EXT = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             glb_safe_i,
   input  logic             glb_reset_i,
   input  logic             go_active_i,
   input  logic             safe_exit_i,
   input  logic [FC_W-1:0]  mcu_fail_cnt_i,
   input  logic [FC_W-1:0]  mcu_fail_th_i,
   input  logic [FC_W-1:0]  wd_fail_cnt_i,
   input  logic [FC_W-1:0]  wd_rst_th_i,
   input  logic             cfg_wr_i,
   input  logic             cfg_to_dis_i,
   input  logic [ERR_W-1:0] cfg_lock_th_i,
   input  logic [1:0]       cfg_to_sel_i,
   input  logic             cfg_wd_rst_en_i,
   input  logic             cfg_drv_en_i,
   output logic [1:0]       state_o,
   output logic             nres_o,
   output logic             endrv_n_o,
   output logic             drv_en_o,
   output logic [ERR_W-1:0] err_cnt_o,
   output logic             safe_lock_o,
   output logic             to_off_o
);
   generate
      if (ERR_W < 2) begin : g_bad_err_w
         $error("fs_supervisor: ERR_W must be at least 2");
      end
      if (FC_W < 1) begin : g_bad_fc_w
         $error("fs_supervisor: FC_W must be at least 1");
      end
      if (TO_BASE < 1) begin : g_bad_base
         $error("fs_supervisor: TO_BASE must be at least 1");
      end
      if (RST_EXT < 1) begin : g_bad_ext
         $error("fs_supervisor: RST_EXT must be at least 1");
      end
   endgenerate

   fs_state_e        st_q;
   fs_state_e        st_d;
   logic             safe_inc;
   logic             tmr_done;
   logic             tmr_run;
   logic             tmr_clear;
   logic             mcu_trip;
   logic             wd_trip;
   logic             lock_on;
   logic             to_off;
   logic [ERR_W-1:0] err_cnt;
   logic             cfg_to_dis;
   logic [ERR_W-1:0] cfg_lock_th;
   logic [SEL_W-1:0] cfg_to_sel;
   logic             cfg_wd_en;
   logic             cfg_drv_en;

   assign mcu_trip = (mcu_fail_th_i != '0) && (mcu_fail_cnt_i >= mcu_fail_th_i);
   assign wd_trip  = cfg_wd_en && (wd_fail_cnt_i >= wd_rst_th_i);
   assign lock_on  = (cfg_lock_th != '0) && (err_cnt >= cfg_lock_th);
   assign to_off   = cfg_to_dis && (err_cnt > cfg_lock_th);

   assign tmr_run   = ((st_q == ST_RESET) && !glb_reset_i) ||
                      ((st_q == ST_SAFE) && !to_off);
   assign tmr_clear = (st_d != st_q) || !tmr_run;

   fs_state_core u_core (
      .clk         (clk),
      .rst_n       (rst_n),
      .glb_reset_i (glb_reset_i),
      .glb_safe_i  (glb_safe_i),
      .mcu_trip_i  (mcu_trip),
      .wd_trip_i   (wd_trip),
      .go_active_i (go_active_i),
      .safe_exit_i (safe_exit_i),
      .lock_i      (lock_on),
      .tmr_done_i  (tmr_done),
      .state_q_o   (st_q),
      .state_d_o   (st_d),
      .safe_inc_o  (safe_inc)
   );

   fs_err_counter #(.ERR_W(ERR_W)) u_err (
      .clk   (clk),
      .rst_n (rst_n),
      .inc_i (safe_inc),
      .cnt_o (err_cnt)
   );

   fs_timer #(
      .TO_BASE (TO_BASE),
      .RST_EXT (RST_EXT),
      .SEL_W   (SEL_W)
   ) u_tmr (
      .clk         (clk),
      .rst_n       (rst_n),
      .clear_i     (tmr_clear),
      .run_i       (tmr_run),
      .safe_mode_i (st_q == ST_SAFE),
      .to_sel_i    (cfg_to_sel),
      .done_o      (tmr_done)
   );

   fs_cfg_regs #(.ERR_W(ERR_W)) u_cfg (
      .clk         (clk),
      .rst_n       (rst_n),
      .state_q_i   (st_q),
      .state_d_i   (st_d),
      .wr_i        (cfg_wr_i),
      .to_dis_i    (cfg_to_dis_i),
      .lock_th_i   (cfg_lock_th_i),
      .to_sel_i    (cfg_to_sel_i),
      .wd_rst_en_i (cfg_wd_rst_en_i),
      .drv_en_i    (cfg_drv_en_i),
      .to_dis_o    (cfg_to_dis),
      .lock_th_o   (cfg_lock_th),
      .to_sel_o    (cfg_to_sel),
      .wd_rst_en_o (cfg_wd_en),
      .drv_en_o    (cfg_drv_en)
   );

   assign state_o     = st_q;
   assign nres_o      = (st_q != ST_RESET);
   assign endrv_n_o   = (st_q == ST_DIAG) || (st_q == ST_ACTIVE);
   assign drv_en_o    = cfg_drv_en;
   assign err_cnt_o   = err_cnt;
   assign safe_lock_o = lock_on;
   assign to_off_o    = to_off;
endmodule

// File: rtl/fs_supervisor_chk.sv
module fs_supervisor_chk #(
   parameter int ERR_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             glb_reset_i,
   input logic             safe_exit_i,
   input logic [1:0]       state_o,
   input logic             nres_o,
   input logic             endrv_n_o,
   input logic             drv_en_o,
   input logic [ERR_W-1:0] err_cnt_o,
   input logic             lock_to_dis,
   input logic [ERR_W-1:0] lock_th
);
   localparam logic [1:0] S_RST = 2'd0;
   localparam logic [1:0] S_DIA = 2'd1;
   localparam logic [1:0] S_ACT = 2'd2;
   localparam logic [1:0] S_SAF = 2'd3;
   localparam logic [ERR_W-1:0] E_MAX = '1;

   assert_safe_outputs_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == S_SAF) |-> (!endrv_n_o && nres_o && !drv_en_o));

   assert_err_monotone_R10: assert property (@(posedge clk) disable iff (!rst_n)
      err_cnt_o >= $past(err_cnt_o));

   assert_err_saturate_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (err_cnt_o == E_MAX) |=> (err_cnt_o == E_MAX));

   assert_err_inc_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(state_o) == S_DIA || $past(state_o) == S_ACT) && state_o == S_SAF &&
       $past(err_cnt_o) != E_MAX) |-> (err_cnt_o == $past(err_cnt_o) + 1'b1));

   assert_no_inc_from_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state_o) == S_RST && state_o == S_SAF) |-> $stable(err_cnt_o));

   assert_cfg_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state_o) != S_DIA) |-> ($stable(lock_th) && $stable(lock_to_dis)));

   assert_reset_prio_R9: assert property (@(posedge clk) disable iff (!rst_n)
      glb_reset_i |=> (state_o == S_RST && !nres_o));

   assert_nres_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(nres_o) |-> !$past(glb_reset_i));

   assert_exit_leaves_safe_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == S_SAF && safe_exit_i) |=> (state_o != S_SAF));

   assert_safe_no_active_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == S_SAF) |=> (state_o != S_ACT));
endmodule

bind fs_supervisor fs_supervisor_chk #(.ERR_W(ERR_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .glb_reset_i (glb_reset_i),
   .safe_exit_i (safe_exit_i),
   .state_o     (state_o),
   .nres_o      (nres_o),
   .endrv_n_o   (endrv_n_o),
   .drv_en_o    (drv_en_o),
   .err_cnt_o   (err_cnt_o),
   .lock_to_dis (cfg_to_dis),
   .lock_th     (cfg_lock_th)
);

// File: tb/fs_supervisor_bench.sv
module fs_supervisor_bench;
   localparam int ERR_W   = 4;
   localparam int FC_W    = 4;
   localparam int TO_BASE = 8;
   localparam int RST_EXT = 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             glb_safe_i = 1'b0;
   logic             glb_reset_i = 1'b0;
   logic             go_active_i = 1'b0;
   logic             safe_exit_i = 1'b0;
   logic [FC_W-1:0]  mcu_fail_cnt_i = '0;
   logic [FC_W-1:0]  mcu_fail_th_i = 4'd3;
   logic [FC_W-1:0]  wd_fail_cnt_i = '0;
   logic [FC_W-1:0]  wd_rst_th_i = 4'd2;
   logic             cfg_wr_i = 1'b0;
   logic             cfg_to_dis_i = 1'b1;
   logic [ERR_W-1:0] cfg_lock_th_i = '0;
   logic [1:0]       cfg_to_sel_i = '0;
   logic             cfg_wd_rst_en_i = 1'b1;
   logic             cfg_drv_en_i = 1'b0;
   logic [1:0]       state_o;
   logic             nres_o;
   logic             endrv_n_o;
   logic             drv_en_o;
   logic [ERR_W-1:0] err_cnt_o;
   logic             safe_lock_o;
   logic             to_off_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4ns clk = ~clk;

   fs_supervisor #(
      .ERR_W(ERR_W), .FC_W(FC_W), .TO_BASE(TO_BASE), .RST_EXT(RST_EXT)
   ) u_fs_supervisor (
      .clk(clk), .rst_n(rst_n), .glb_safe_i(glb_safe_i), .glb_reset_i(glb_reset_i),
      .go_active_i(go_active_i), .safe_exit_i(safe_exit_i),
      .mcu_fail_cnt_i(mcu_fail_cnt_i), .mcu_fail_th_i(mcu_fail_th_i),
      .wd_fail_cnt_i(wd_fail_cnt_i), .wd_rst_th_i(wd_rst_th_i),
      .cfg_wr_i(cfg_wr_i), .cfg_to_dis_i(cfg_to_dis_i), .cfg_lock_th_i(cfg_lock_th_i),
      .cfg_to_sel_i(cfg_to_sel_i), .cfg_wd_rst_en_i(cfg_wd_rst_en_i),
      .cfg_drv_en_i(cfg_drv_en_i), .state_o(state_o), .nres_o(nres_o),
      .endrv_n_o(endrv_n_o), .drv_en_o(drv_en_o), .err_cnt_o(err_cnt_o),
      .safe_lock_o(safe_lock_o), .to_off_o(to_off_o)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic count_until(input int target, input int maxn, output int n);
      n = 0;
      while (int'(state_o) != target && n < maxn) begin
         step(1);
         n++;
      end
   endtask

   task automatic pulse_safe();
      glb_safe_i = 1'b1; step(1); glb_safe_i = 1'b0;
   endtask

   task automatic pulse_exit();
      safe_exit_i = 1'b1; step(1); safe_exit_i = 1'b0;
   endtask

   task automatic cfg_write(input bit dis, input int lth, input int sel, input bit drv);
      cfg_to_dis_i = dis; cfg_lock_th_i = ERR_W'(lth); cfg_to_sel_i = 2'(sel);
      cfg_wd_rst_en_i = 1'b1; cfg_drv_en_i = drv;
      cfg_wr_i = 1'b1; step(1); cfg_wr_i = 1'b0;
   endtask

   task automatic t_reset_defaults();
      step(2);
      chk("R8 reset state", int'(state_o), 0);
      chk("R9 nres low in reset", int'(nres_o), 0);
      chk("R10 err cleared", int'(err_cnt_o), 0);
      chk("R8 drv_en default", int'(drv_en_o), 0);
      chk("R2 no lock at default", int'(safe_lock_o), 0);
   endtask

   task automatic t_extension();
      int n;
      rst_n = 1'b1;
      count_until(1, 50, n);
      chk("R9 extension length", n, RST_EXT);
      chk("R9 nres high after", int'(nres_o), 1);
   endtask

   task automatic t_wd_default();
      int n;
      wd_fail_cnt_i = 4'd2; step(1);
      chk("R5 wd reset from diag, default enable R8", int'(state_o), 0);
      wd_fail_cnt_i = '0;
      count_until(1, 50, n);
      chk("R2 lock threshold 0 means no lock", n, RST_EXT);
   endtask

   task automatic t_first_safe();
      cfg_write(1'b1, 2, 0, 1'b1);
      chk("R8 drv_en written in diag", int'(drv_en_o), 1);
      go_active_i = 1'b1; step(1); go_active_i = 1'b0;
      chk("R1 go active", int'(state_o), 2);
      pulse_safe();
      chk("R1 glb safe enters safe", int'(state_o), 3);
      chk("R3 err increments", int'(err_cnt_o), 1);
      chk("R4 endrv_n low", int'(endrv_n_o), 0);
      chk("R4 nres high", int'(nres_o), 1);
      chk("R4 drv_en cleared", int'(drv_en_o), 0);
   endtask

   task automatic t_timeout_base();
      int n;
      chk("R7 timeout active", int'(to_off_o), 0);
      count_until(0, 100, n);
      chk("R7 timeout length sel0", n, TO_BASE);
      count_until(1, 50, n);
      chk("R2 below threshold goes diag", n, RST_EXT);
   endtask

   task automatic t_mcu_and_exit();
      mcu_fail_cnt_i = 4'd3; step(1); mcu_fail_cnt_i = '0;
      chk("R1 mcu count trip", int'(state_o), 3);
      chk("R3 err now 2", int'(err_cnt_o), 2);
      chk("R2 lock reported", int'(safe_lock_o), 1);
      pulse_exit();
      chk("R6 exit to diag", int'(state_o), 1);
   endtask

   task automatic t_cfg_ignored();
      go_active_i = 1'b1; step(1); go_active_i = 1'b0;
      cfg_write(1'b0, 0, 0, 1'b1);
      chk("R8 lock threshold write ignored in active", int'(safe_lock_o), 1);
      chk("R8 drv_en written in active", int'(drv_en_o), 1);
   endtask

   task automatic t_lock_reset();
      int n;
      glb_reset_i = 1'b1; step(3);
      chk("R9 global reset", int'(state_o), 0);
      chk("R9 nres low", int'(nres_o), 0);
      glb_reset_i = 1'b0;
      count_until(3, 50, n);
      chk("R2 lock returns to safe", n, RST_EXT);
      chk("R2 no increment from reset", int'(err_cnt_o), 2);
   endtask

   task automatic t_wd_mask();
      int n;
      wd_fail_cnt_i = 4'd2;
      for (int i = 0; i < 5; i++) begin
         step(1);
         chk("R5 wd reset masked in safe", int'(state_o), 3);
      end
      pulse_exit();
      chk("R6 exit with wd pending goes reset", int'(state_o), 0);
      wd_fail_cnt_i = '0;
      count_until(3, 50, n);
      chk("R2 locked again", n, RST_EXT);
   endtask

   task automatic t_to_off();
      pulse_exit();
      chk("R6 exit to diag", int'(state_o), 1);
      cfg_write(1'b1, 1, 0, 1'b0);
      chk("R7 timeout off when err above th", int'(to_off_o), 1);
      pulse_safe();
      chk("R3 err 3", int'(err_cnt_o), 3);
      step(40);
      chk("R7 no timeout when off", int'(state_o), 3);
      pulse_exit();
   endtask

   task automatic t_duration();
      int n;
      cfg_write(1'b0, 1, 2, 1'b0);
      chk("R7 timeout on with dis 0", int'(to_off_o), 0);
      pulse_safe();
      count_until(0, 200, n);
      chk("R7 timeout length sel2", n, TO_BASE * 4);
      count_until(3, 50, n);
      chk("R2 locked after timeout", n, RST_EXT);
      pulse_exit();
   endtask

   task automatic t_saturate();
      cfg_write(1'b0, 0, 0, 1'b0);
      for (int i = 0; i < 11; i++) begin
         pulse_safe();
         pulse_exit();
      end
      chk("R10 err reaches max", int'(err_cnt_o), 15);
      pulse_safe();
      chk("R10 entered safe", int'(state_o), 3);
      chk("R10 err saturates", int'(err_cnt_o), 15);
   endtask

   initial begin
      t_reset_defaults();
      t_extension();
      t_wd_default();
      t_first_safe();
      t_timeout_base();
      t_mcu_and_exit();
      t_cfg_ignored();
      t_lock_reset();
      t_wd_mask();
      t_to_off();
      t_duration();
      t_saturate();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog (R1..): run did not complete, actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule